// File: doc/BRIEF.md
# Per-Pin LED Blink and Dimming Modulator

This block forms the value of each LED output bit for a serial LED shifter, one bit per pin, for 32 pins. Each pin is dimmed by pulse-width modulation from its own 8-bit duty value. It can also be blinked at a rate taken from one of two tick sources, or handed over to a hardware signal that bypasses both. The configuration arrives as plain register-image inputs. The two source clocks arrive as single-cycle enable pulses: a divided peripheral tick and a timer tick.

A shared rate generator divides each tick source by four fixed ratios (4000, 2000, 1000 and 800 by default). It emits a strobe at every half period, that is after ratio/2 source ticks. The undivided timer tick serves as a third, high-speed source. Each of the eight upper pins selects its own source and ratio through a 6-bit field. The 24 lower pins share one field.

Each pin holds a two-state blink phase machine with the states PH_ON and PH_OFF. The transition TOGGLE moves PH_ON to PH_OFF, or PH_OFF to PH_ON, on a strobe of the pin's selected rate while its blink enable is set. The transition CLEAR returns either state to PH_ON whenever the blink enable is low. A strobe with the enable low is ignored. In all other cases the state holds.

Top module: `led_blink_dim`

## Requirements
- R1: While `rst_n` is low, `pin_out` is all zero and every blink phase is PH_ON. The PWM counter and all rate counters are cleared.
- R2: An 8-bit PWM counter increments every cycle and wraps. A pin that is not under direct control and not in PH_OFF drives high while the counter is below its duty value. A duty of 0xFF drives high on every cycle. Over any 256 consecutive cycles, a duty D below 0xFF gives exactly D high cycles.
- R3: A duty value of 0 drives the pin low on every cycle unless the pin is under direct control.
- R4: A pin with its blink enable low never enters an off phase, so its output is its PWM value alone.
- R5: Rate code c selects ratio RATIO_c of its source: c=0 gives 4000, c=1 gives 2000, c=2 gives 1000 and c=3 gives 800. The blink phase toggles once every RATIO_c/2 source ticks.
- R6: In a pin's 6-bit field, bits [5:4] select the source. The value 0 selects the divided tick, with the rate in bits [1:0]. The value 1 selects the timer tick, with the rate in bits [3:2]. The value 2 selects the undivided timer, which toggles on every timer tick. The value 3 freezes the phase.
- R7: The field for pin p, with p from 24 to 28, sits in `rate_a` at bits [(p-24)*6 +: 6]. The field for pin p, with p from 29 to 31, sits in `rate_b` at bits [(p-29)*6 +: 6]. Pins 0 to 23 all use `rate_b[23:18]`.
- R8: In PH_OFF the pin drives 0 whatever its duty value. In PH_ON it drives its PWM value.
- R9: Clearing a pin's blink enable returns its phase to PH_ON, so the next blink after re-enabling starts with an on phase.
- R10: A pin with its `direct_en` bit set drives its `hw_val` bit. Its duty value and blink settings have no effect on it.
- R11: `pin_out` is registered. A change on `hw_val`, `direct_en`, `blink_en` or the duty inputs shows at the output after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_tick | input | 1 | One-cycle pulse from the divided peripheral clock |
| tmr_tick | input | 1 | One-cycle pulse from the timer clock |
| duty_flat | input | NPIN*8 | Duty value of pin p at bits [p*8 +: 8] |
| blink_en | input | NPIN | Blink enable, one bit per pin |
| direct_en | input | NPIN | Direct hardware control enable, one bit per pin |
| hw_val | input | NPIN | Hardware value used for pins under direct control |
| rate_a | input | REG_W | Rate fields of pins 24 to 28 |
| rate_b | input | REG_W | Rate fields of pins 29 to 31, plus the shared field of the lower pins |
| pin_out | output | NPIN | Modulated value of each pin |

## Verification
The properties take the configuration inputs as sampled at each rising edge and assume no stability between edges. They do assume that both tick inputs are synchronous to `clk`, and they relate the output only to the inputs of the edge before. The bench changes every input, ticks included, only at falling edges. It generates the timer tick on every cycle and the divided tick on every second cycle, so each half period is an exact cycle count. Blink timing is measured between successive output transitions, so the phase of the free-running rate counters when a test starts does not matter.

// File: rtl/led_mod_pkg.sv
package led_mod_pkg;

    typedef enum logic [1:0] {
        SRC_DIV  = 2'd0,
        SRC_TMR  = 2'd1,
        SRC_HS   = 2'd2,
        SRC_HOLD = 2'd3
    } src_e;

    // 6-bit per-pin rate field: [5:4] source, [3:2] timer rate, [1:0] divided rate
    typedef struct packed {
        src_e       src;
        logic [1:0] tmr_rate;
        logic [1:0] div_rate;
    } rate_fld_t;

    localparam int FLD_W = $bits(rate_fld_t);

    typedef enum logic {
        PH_ON  = 1'b0,
        PH_OFF = 1'b1
    } phase_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/led_rate_gen.sv
module led_rate_gen
    import led_mod_pkg::*;
#(
    parameter int unsigned RATIO_0 = 4000,
    parameter int unsigned RATIO_1 = 2000,
    parameter int unsigned RATIO_2 = 1000,
    parameter int unsigned RATIO_3 = 800,
    parameter int unsigned N_RATE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_tick,
    input  logic              tmr_tick,
    output logic [N_RATE-1:0] div_stb,
    output logic [N_RATE-1:0] tmr_stb
);

    localparam int unsigned HMAX = max4(RATIO_0, RATIO_1, RATIO_2, RATIO_3) / 2;
    localparam int unsigned CW   = $clog2(HMAX + 1);

    for (genvar g = 0; g < 2; g++) begin : g_src
        logic src_tick;
        logic [N_RATE-1:0] stb;
        assign src_tick = (g == 0) ? div_tick : tmr_tick;

        for (genvar r = 0; r < N_RATE; r++) begin : g_rate
            localparam int unsigned HALF = ((r == 0) ? RATIO_0 :
                                            (r == 1) ? RATIO_1 :
                                            (r == 2) ? RATIO_2 : RATIO_3) / 2;
            logic [CW-1:0] cnt;
            logic          wrap;
            assign wrap   = (cnt == CW'(HALF - 1));
            assign stb[r] = src_tick && wrap;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (src_tick) begin
                    cnt <= wrap ? '0 : cnt + 1'b1;
                end
            end
        end
    end

    assign div_stb = g_src[0].stb;
    assign tmr_stb = g_src[1].stb;

endmodule

// File: rtl/led_pin_cell.sv
module led_pin_cell
    import led_mod_pkg::*;
#(
    parameter int unsigned N_RATE = 4,
    parameter int unsigned DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rate_fld_t         fld,
    input  logic [N_RATE-1:0] div_stb,
    input  logic [N_RATE-1:0] tmr_stb,
    input  logic              hs_stb,
    input  logic              blink_en,
    input  logic              direct_en,
    input  logic              hw_val,
    input  logic [DUTY_W-1:0] duty,
    input  logic [DUTY_W-1:0] pwm_cnt,
    output logic              pin_out
);

    localparam logic [DUTY_W-1:0] DUTY_FULL = '1;

    phase_e state, nxt;
    logic   stb;
    logic   pwm_hit;

    always_comb begin
        unique case (fld.src)
            SRC_DIV:  stb = div_stb[fld.div_rate];
            SRC_TMR:  stb = tmr_stb[fld.tmr_rate];
            SRC_HS:   stb = hs_stb;
            SRC_HOLD: stb = 1'b0;
            default:  stb = 1'b0;
        endcase
    end

    // CLEAR has priority over TOGGLE
    always_comb begin
        nxt = state;
        if (!blink_en) begin
            nxt = PH_ON;
        end else if (stb) begin
            unique case (state)
                PH_ON:   nxt = PH_OFF;
                PH_OFF:  nxt = PH_ON;
                default: nxt = PH_ON;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PH_ON;
        else        state <= nxt;
    end

    assign pwm_hit = (duty == DUTY_FULL) || (pwm_cnt < duty);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_out <= 1'b0;
        end else if (direct_en) begin
            pin_out <= hw_val;
        end else if (blink_en && (state == PH_OFF)) begin
            pin_out <= 1'b0;
        end else begin
            pin_out <= pwm_hit;
        end
    end

endmodule

// File: rtl/led_blink_dim.sv
module led_blink_dim
    import led_mod_pkg::*;
#(
    parameter int unsigned NPIN        = 32,
    parameter int unsigned REG_W       = 32,
    parameter int unsigned DUTY_W      = 8,
    parameter int unsigned N_RATE      = 4,
    parameter int unsigned GRP_A_FIRST = 24,
    parameter int unsigned GRP_B_FIRST = 29,
    parameter int unsigned RATIO_0     = 4000,
    parameter int unsigned RATIO_1     = 2000,
    parameter int unsigned RATIO_2     = 1000,
    parameter int unsigned RATIO_3     = 800
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     div_tick,
    input  logic                     tmr_tick,
    input  logic [NPIN*DUTY_W-1:0]   duty_flat,
    input  logic [NPIN-1:0]          blink_en,
    input  logic [NPIN-1:0]          direct_en,
    input  logic [NPIN-1:0]          hw_val,
    input  logic [REG_W-1:0]         rate_a,
    input  logic [REG_W-1:0]         rate_b,
    output logic [NPIN-1:0]          pin_out
);

    // the shared lower-pin slot follows the upper pins in rate_b
    localparam int unsigned SHARED_LO = (NPIN - GRP_B_FIRST) * FLD_W;

    logic [N_RATE-1:0] div_stb;
    logic [N_RATE-1:0] tmr_stb;
    logic [DUTY_W-1:0] pwm_cnt;

    led_rate_gen #(
        .RATIO_0 (RATIO_0),
        .RATIO_1 (RATIO_1),
        .RATIO_2 (RATIO_2),
        .RATIO_3 (RATIO_3),
        .N_RATE  (N_RATE)
    ) u_rate (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_tick (div_tick),
        .tmr_tick (tmr_tick),
        .div_stb  (div_stb),
        .tmr_stb  (tmr_stb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_cnt <= '0;
        else        pwm_cnt <= pwm_cnt + 1'b1;
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        rate_fld_t fld;

        if (p >= GRP_B_FIRST) begin : g_hi_b
            assign fld = rate_fld_t'(rate_b[(p - GRP_B_FIRST) * FLD_W +: FLD_W]);
        end else if (p >= GRP_A_FIRST) begin : g_hi_a
            assign fld = rate_fld_t'(rate_a[(p - GRP_A_FIRST) * FLD_W +: FLD_W]);
        end else begin : g_lo
            assign fld = rate_fld_t'(rate_b[SHARED_LO +: FLD_W]);
        end

        led_pin_cell #(
            .N_RATE (N_RATE),
            .DUTY_W (DUTY_W)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .fld       (fld),
            .div_stb   (div_stb),
            .tmr_stb   (tmr_stb),
            .hs_stb    (tmr_tick),
            .blink_en  (blink_en[p]),
            .direct_en (direct_en[p]),
            .hw_val    (hw_val[p]),
            .duty      (duty_flat[p*DUTY_W +: DUTY_W]),
            .pwm_cnt   (pwm_cnt),
            .pin_out   (pin_out[p])
        );
    end

endmodule

// File: rtl/led_blink_dim_chk.sv
module led_blink_dim_chk #(
    parameter int unsigned NPIN   = 32,
    parameter int unsigned DUTY_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPIN*DUTY_W-1:0] duty_flat,
    input logic [NPIN-1:0]        blink_en,
    input logic [NPIN-1:0]        direct_en,
    input logic [NPIN-1:0]        hw_val,
    input logic [NPIN-1:0]        pin_out
);

    logic [NPIN-1:0] zero_m;
    logic [NPIN-1:0] full_m;

    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            zero_m[i] = (duty_flat[i*DUTY_W +: DUTY_W] == '0);
            full_m[i] = (duty_flat[i*DUTY_W +: DUTY_W] == '1);
        end
    end

    // R1: output cleared while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_low: assert (pin_out == '0);
        end
    end

    // R10, R11: direct-control pins copy hw_val one edge later
    a_r10_direct_follow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        ((pin_out & $past(direct_en)) == ($past(hw_val) & $past(direct_en))));

    // R3: zero duty keeps a pin low
    a_r3_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        ((pin_out & ~$past(direct_en) & $past(zero_m)) == '0));

    // R2, R4: full duty without blink stays high
    a_r2_full_duty_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        ((~pin_out & ~$past(direct_en) & ~$past(blink_en) & $past(full_m)) == '0));

    // R8: any high pin that is not direct has a nonzero duty
    a_r8_high_needs_duty: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        (((pin_out & ~$past(direct_en)) & $past(zero_m)) == '0));

endmodule

bind led_blink_dim led_blink_dim_chk #(
    .NPIN   (NPIN),
    .DUTY_W (DUTY_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .duty_flat (duty_flat),
    .blink_en  (blink_en),
    .direct_en (direct_en),
    .hw_val    (hw_val),
    .pin_out   (pin_out)
);

// File: tb/led_blink_dim_tb.sv
module led_blink_dim_tb;

    localparam int NPIN = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              div_tick = 1'b0;
    logic              tmr_tick = 1'b0;
    logic [NPIN*8-1:0] duty_flat = '0;
    logic [NPIN-1:0]   blink_en = '0;
    logic [NPIN-1:0]   direct_en = '0;
    logic [NPIN-1:0]   hw_val = '0;
    logic [31:0]       rate_a = '0;
    logic [31:0]       rate_b = '0;
    logic [NPIN-1:0]   pin_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  tmr_on = 1'b0;
    bit  div_on = 1'b0;
    int  tcnt = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    led_blink_dim u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .div_tick  (div_tick),
        .tmr_tick  (tmr_tick),
        .duty_flat (duty_flat),
        .blink_en  (blink_en),
        .direct_en (direct_en),
        .hw_val    (hw_val),
        .rate_a    (rate_a),
        .rate_b    (rate_b),
        .pin_out   (pin_out)
    );

    // tick pattern: timer every cycle, divided tick every second cycle
    initial begin
        forever begin
            @(negedge clk);
            tcnt++;
            tmr_tick = tmr_on;
            div_tick = div_on && tcnt[0];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_duty(input int p, input logic [7:0] v);
        duty_flat[p*8 +: 8] = v;
    endtask

    task automatic clear_cfg();
        @(negedge clk);
        duty_flat = '0; blink_en = '0; direct_en = '0; hw_val = '0;
        rate_a = '0; rate_b = '0;
        tmr_on = 1'b1; div_on = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic count_high(input int p, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin_out[p]) hi++;
        end
    endtask

    task automatic wait_level(input int p, input bit v, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (pin_out[p] == v) begin ok = 1'b1; break; end
        end
    endtask

    // cycles between two successive output transitions
    task automatic measure_half(input int p, output int n);
        bit v;
        bit ok;
        v = pin_out[p];
        wait_level(p, !v, ok);
        n = 0;
        if (!ok) return;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            n++;
            if (pin_out[p] == v) return;
        end
        n = 0;
    endtask

    task automatic t_reset();
        int hi;
        @(negedge clk);
        chk(pin_out == '0, "R1 reset output", int'(pin_out), 0);
        rst_n = 1'b1;
        count_high(3, 20, hi);
        chk(hi == 0, "R1 idle after reset", hi, 0);
    endtask

    task automatic t_pwm();
        int hi;
        clear_cfg();
        set_duty(2, 8'h40); set_duty(9, 8'h80); set_duty(12, 8'hFF); set_duty(13, 8'h01);
        @(negedge clk);
        count_high(2, 256, hi);  chk(hi == 64,  "R2 duty 0x40", hi, 64);
        count_high(9, 256, hi);  chk(hi == 128, "R2 duty 0x80", hi, 128);
        count_high(12, 300, hi); chk(hi == 300, "R2 duty 0xFF", hi, 300);
        count_high(13, 256, hi); chk(hi == 1,   "R2 duty 0x01", hi, 1);
        count_high(4, 256, hi);  chk(hi == 0,   "R3 duty zero", hi, 0);
        // R4: timer rate set on the lower slot but blink disabled
        rate_b[23:18] = 6'b011100;
        count_high(12, 1000, hi); chk(hi == 1000, "R4 no blink when disabled", hi, 1000);
    endtask

    task automatic t_direct();
        clear_cfg();
        set_duty(5, 8'hFF); set_duty(6, 8'h00);
        blink_en[5] = 1'b1; rate_b[23:18] = 6'b100000;
        direct_en[5] = 1'b1; direct_en[6] = 1'b1;
        hw_val[5] = 1'b0; hw_val[6] = 1'b1;
        @(negedge clk);
        chk(pin_out[5] == 1'b0, "R11 direct low after one edge", int'(pin_out[5]), 0);
        chk(pin_out[6] == 1'b1, "R11 direct high after one edge", int'(pin_out[6]), 1);
        for (int i = 0; i < 6; i++) begin
            hw_val[5] = ~hw_val[5];
            set_duty(5, 8'(i * 40));
            @(negedge clk);
            chk(pin_out[5] == hw_val[5], "R10 direct ignores duty and blink",
                int'(pin_out[5]), int'(hw_val[5]));
        end
    endtask

    task automatic t_rates();
        int n;
        int exp_t [4] = '{2000, 1000, 500, 400};
        clear_cfg();
        set_duty(30, 8'hFF); blink_en[30] = 1'b1;
        for (int c = 0; c < 4; c++) begin
            rate_b[11:6] = {2'd1, 2'(c), 2'd0};
            measure_half(30, n);
            measure_half(30, n);
            chk(n == exp_t[c], $sformatf("R5 timer rate code %0d", c), n, exp_t[c]);
        end
        // divided source on pin 24, rate code 2: 500 ticks, one tick per 2 cycles
        set_duty(24, 8'hFF); blink_en[24] = 1'b1; rate_a[5:0] = 6'b000010;
        measure_half(24, n);
        measure_half(24, n);
        chk(n == 1000, "R6 divided source rate 2", n, 1000);
        // undivided timer on pin 31
        set_duty(31, 8'hFF); blink_en[31] = 1'b1; rate_b[17:12] = 6'b100000;
        measure_half(31, n);
        measure_half(31, n);
        chk(n == 1, "R6 undivided timer", n, 1);
    endtask

    task automatic t_fields();
        int n;
        int hi;
        clear_cfg();
        set_duty(28, 8'hFF); blink_en[28] = 1'b1; rate_a[29:24] = 6'b011100;
        measure_half(28, n);
        measure_half(28, n);
        chk(n == 400, "R7 pin 28 field in rate_a", n, 400);
        set_duty(0, 8'hFF); set_duty(23, 8'hFF);
        blink_en[0] = 1'b1; blink_en[23] = 1'b1; rate_b[23:18] = 6'b011100;
        measure_half(0, n);
        measure_half(0, n);
        chk(n == 400, "R7 pin 0 shared slot", n, 400);
        measure_half(23, n);
        measure_half(23, n);
        chk(n == 400, "R7 pin 23 shared slot", n, 400);
        // frozen source keeps pin 26 on
        set_duty(26, 8'hFF); blink_en[26] = 1'b1; rate_a[17:12] = 6'b110000;
        count_high(26, 3000, hi);
        chk(hi == 3000, "R6 hold source freezes phase", hi, 3000);
    endtask

    task automatic t_off_phase();
        bit ok;
        int hi;
        clear_cfg();
        set_duty(30, 8'hFF); blink_en[30] = 1'b1; rate_b[11:6] = 6'b011100;
        wait_level(30, 1'b1, ok);
        wait_level(30, 1'b0, ok);
        chk(ok, "R8 off phase reached", int'(ok), 1);
        set_duty(30, 8'h80);
        count_high(30, 256, hi);
        chk(hi == 0, "R8 off phase forces low", hi, 0);
        repeat (146) @(negedge clk);
        count_high(30, 256, hi);
        chk(hi == 128, "R8 on phase gives PWM", hi, 128);
    endtask

    task automatic t_clear();
        bit ok;
        int hi;
        clear_cfg();
        set_duty(30, 8'hFF); blink_en[30] = 1'b1; rate_b[11:6] = 6'b010000;
        wait_level(30, 1'b1, ok);
        wait_level(30, 1'b0, ok);
        blink_en[30] = 1'b0;
        @(negedge clk);
        blink_en[30] = 1'b1;
        @(negedge clk);
        chk(pin_out[30] == 1'b1, "R9 restart in on phase", int'(pin_out[30]), 1);
        count_high(30, 100, hi);
        chk(hi == 100, "R9 on phase held after restart", hi, 100);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        t_pwm();
        t_direct();
        t_rates();
        t_fields();
        t_off_phase();
        t_clear();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

endmodule